// File: doc/BRIEF.md
# Two-Phase Converter Start-Up Sequencer

This block brings up a two-rail isolated power converter. When the input supply is good and the enable pin is high, it first runs an open-loop phase. In that phase a burst duty-cycle code climbs in eighths from one eighth to one half, which limits inrush current. When the primary rail reports that it is above the level where the secondary-side feedback works, control passes to a closed-loop phase. There the block steps a reference code through an uneven staircase and enables the auxiliary rail's source-sink regulator once the primary rail is out of undervoltage.

Power-good is active low. During start-up it is issued only after the rail health flags have stayed good for a deglitch window. After it has been issued, it follows the flags with no deglitch. If the primary rail never reaches the handover level within a timeout, the block latches a safe shutdown. Only a low enable or a reset clears that shutdown.

All timing is counted in ticks of an external strobe, nominally 1 MHz. The duty interval, reference step length, deglitch window and timeout are parameters.

Top module: `softstart_seq`

## Requirements
- R1: The block leaves idle only when `en_i` and `vin_ok_i` are both high. In idle, `duty_code_o`=0, `ref_code_o`=0, `fb_mode_o`=0, `aux_reg_en_o`=0, `safe_o`=0 and `pg_n_o`=1.
- R2: The open-loop phase starts with `duty_code_o`=1, where code n means a duty of n/8. The code rises by one after each `DUTY_TICKS` ticks and stops at 4.
- R3: In the open-loop phase, a high `vdd_sec_ok_i` moves the block on the next clock to the closed-loop phase. There `fb_mode_o`=1 (ramp released high) and `duty_code_o`=0.
- R4: `ref_code_o` is the reference in units of 100 mV. It is 9 on entering the closed-loop phase and becomes 13 after `STEP_TICKS` ticks. After that it rises by 2 every `STEP_TICKS` ticks until it reaches 25, where it stays.
- R5: In the closed-loop phase, `aux_reg_en_o` goes high on the clock after `vdd_uv_ok_i` is seen high. It stays high until the phase is left.
- R6: Rail health is good when `vdd_uv_ok_i`=1, `aux_uv_ok_i`=1 and `ovp_i`=0. Before the first power-good, `pg_n_o` falls only after `DEGLITCH_TICKS` ticks of unbroken good health. Any cycle that is not good restarts the count.
- R7: After power-good has been issued, `pg_n_o` equals the inverse of rail health, one clock later, with no deglitch.
- R8: If the open-loop phase lasts `TIMEOUT_TICKS` ticks without a handover, the block enters safe shutdown. There `safe_o`=1, `pg_n_o`=1 and the duty, reference and regulator outputs are 0.
- R9: Safe shutdown is latched. Changes on `vin_ok_i` or `vdd_sec_ok_i` have no effect. Only a low `en_i` (back to idle on the next clock) or a reset clears it.
- R10: A low `en_i` or a low `vin_ok_i` in either start-up phase returns the block to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timebase strobe (nominally 1 MHz) |
| en_i | input | 1 | Converter enable |
| vin_ok_i | input | 1 | Input supply above its undervoltage threshold |
| vdd_sec_ok_i | input | 1 | Primary rail above the secondary-side UVLO level |
| vdd_uv_ok_i | input | 1 | Primary rail above its undervoltage-protection threshold |
| aux_uv_ok_i | input | 1 | Auxiliary rail above its undervoltage-protection threshold |
| ovp_i | input | 1 | Overvoltage flag on either rail |
| duty_code_o | output | 3 | Open-loop burst duty in eighths, 0 outside that phase |
| fb_mode_o | output | 1 | Closed-loop phase active; primary ramp released high |
| ref_code_o | output | 5 | Reference DAC code in 100 mV units |
| aux_reg_en_o | output | 1 | Auxiliary rail source-sink regulator enable |
| pg_n_o | output | 1 | Power good, active low |
| safe_o | output | 1 | Latched safe shutdown |

## Verification
Some rules are checked by assertions on every cycle. Idle holds while the start condition is missing. The duty code stays within one to four eighths and never falls during the ramp. The reference only holds or moves to its next staircase value. The regulator enable and power-good appear only in the closed-loop phase. Safe shutdown holds while enable stays high, and a low enable aborts either start-up phase.

The bench scenarios are the only place the exact tick counts are shown. These cover the duty interval, the uneven first reference step and the deglitch window, including its restart after a one-cycle glitch. The scenarios also cover the timeout instant, the undeglitched power-good tracking after issue, and the restart from idle after a safe shutdown.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAMP   = 2'd1,
        ST_CLOSED = 2'd2,
        ST_SAFE   = 2'd3
    } ss_state_e;

    localparam int DUTY_W = 3;
    localparam int REF_W  = 5;

    localparam logic [DUTY_W-1:0] DUTY_FIRST = 3'd1;
    localparam logic [DUTY_W-1:0] DUTY_LAST  = 3'd4;

    localparam logic [REF_W-1:0] REF_FIRST  = 5'd9;
    localparam logic [REF_W-1:0] REF_SECOND = 5'd13;
    localparam logic [REF_W-1:0] REF_INC    = 5'd2;
    localparam logic [REF_W-1:0] REF_TOP    = 5'd25;

    typedef struct packed {
        ss_state_e         state;
        logic [DUTY_W-1:0] duty;
        logic [REF_W-1:0]  refc;
        logic              aux_en;
        logic              pg_seen;
        logic              pg_n;
    } ss_ctrl_t;

    localparam ss_ctrl_t CTRL_IDLE = '{
        state:   ST_IDLE,
        duty:    '0,
        refc:    '0,
        aux_en:  1'b0,
        pg_seen: 1'b0,
        pg_n:    1'b1
    };

    function automatic logic [REF_W-1:0] ref_after(input logic [REF_W-1:0] cur);
        if (cur == REF_FIRST)
            return REF_SECOND;
        else if (cur >= REF_TOP)
            return REF_TOP;
        else
            return cur + REF_INC;
    endfunction

endpackage

// File: rtl/ss_tick_timer.sv
module ss_tick_timer #(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && tick_i && (cnt_q == CW'(LIMIT - 1));
        cnt_d    = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (expire_o)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // Supports R2, R4, R6 and R8: a window counter never passes its limit
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

    // Supports R6: a stopped timer restarts from zero
    a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_seq_pkg::*;
#(
    parameter int DUTY_TICKS     = 128,
    parameter int STEP_TICKS     = 128,
    parameter int DEGLITCH_TICKS = 3000,
    parameter int TIMEOUT_TICKS  = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             vin_ok_i,
    input  logic             vdd_sec_ok_i,
    input  logic             vdd_uv_ok_i,
    input  logic             aux_uv_ok_i,
    input  logic             ovp_i,
    output logic [DUTY_W-1:0] duty_code_o,
    output logic             fb_mode_o,
    output logic [REF_W-1:0] ref_code_o,
    output logic             aux_reg_en_o,
    output logic             pg_n_o,
    output logic             safe_o
);

    ss_ctrl_t ctrl_d, ctrl_q;

    logic in_ramp, in_closed, health_ok, start_ok;
    logic duty_exp, step_exp, dg_exp, to_exp;

    assign in_ramp   = (ctrl_q.state == ST_RAMP);
    assign in_closed = (ctrl_q.state == ST_CLOSED);
    assign health_ok = vdd_uv_ok_i && aux_uv_ok_i && !ovp_i;
    assign start_ok  = en_i && vin_ok_i;

    ss_tick_timer #(.LIMIT(DUTY_TICKS)) u_duty_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .run_i(in_ramp), .expire_o(duty_exp)
    );

    ss_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_tout_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .run_i(in_ramp), .expire_o(to_exp)
    );

    ss_tick_timer #(.LIMIT(STEP_TICKS)) u_step_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .run_i(in_closed), .expire_o(step_exp)
    );

    ss_tick_timer #(.LIMIT(DEGLITCH_TICKS)) u_dg_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .run_i(in_closed && !ctrl_q.pg_seen && health_ok), .expire_o(dg_exp)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (start_ok) begin
                    ctrl_d       = CTRL_IDLE;
                    ctrl_d.state = ST_RAMP;
                    ctrl_d.duty  = DUTY_FIRST;
                end
            end
            ST_RAMP: begin
                if (!start_ok) begin
                    ctrl_d = CTRL_IDLE;
                end else if (vdd_sec_ok_i) begin
                    ctrl_d       = CTRL_IDLE;
                    ctrl_d.state = ST_CLOSED;
                    ctrl_d.refc  = REF_FIRST;
                end else if (to_exp) begin
                    ctrl_d       = CTRL_IDLE;
                    ctrl_d.state = ST_SAFE;
                end else if (duty_exp && (ctrl_q.duty < DUTY_LAST)) begin
                    ctrl_d.duty = ctrl_q.duty + 1'b1;
                end
            end
            ST_CLOSED: begin
                if (!start_ok) begin
                    ctrl_d = CTRL_IDLE;
                end else begin
                    if (step_exp)
                        ctrl_d.refc = ref_after(ctrl_q.refc);
                    if (vdd_uv_ok_i)
                        ctrl_d.aux_en = 1'b1;
                    if (ctrl_q.pg_seen) begin
                        ctrl_d.pg_n = !health_ok;
                    end else if (dg_exp) begin
                        ctrl_d.pg_seen = 1'b1;
                        ctrl_d.pg_n    = 1'b0;
                    end
                end
            end
            ST_SAFE: begin
                if (!en_i)
                    ctrl_d = CTRL_IDLE;
            end
            default: ctrl_d = CTRL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= CTRL_IDLE;
        else
            ctrl_q <= ctrl_d;
    end

    assign duty_code_o  = ctrl_q.duty;
    assign fb_mode_o    = in_closed;
    assign ref_code_o   = ctrl_q.refc;
    assign aux_reg_en_o = ctrl_q.aux_en;
    assign pg_n_o       = ctrl_q.pg_n;
    assign safe_o       = (ctrl_q.state == ST_SAFE);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE && !(en_i && vin_ok_i)) |=> ctrl_q.state == ST_IDLE);

    a_r2_duty_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_ramp |-> (duty_code_o >= DUTY_FIRST && duty_code_o <= DUTY_LAST));

    a_r2_duty_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        in_ramp |=> (!in_ramp || duty_code_o >= $past(duty_code_o)));

    a_r3_closed_no_duty: assert property (@(posedge clk) disable iff (!rst_n)
        fb_mode_o |-> duty_code_o == '0);

    a_r4_ref_staircase: assert property (@(posedge clk) disable iff (!rst_n)
        in_closed |=> (!in_closed || ref_code_o == $past(ref_code_o)
                       || ref_code_o == ref_after($past(ref_code_o))));

    a_r5_aux_in_closed: assert property (@(posedge clk) disable iff (!rst_n)
        aux_reg_en_o |-> in_closed);

    a_r6_pg_in_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_n_o |-> in_closed);

    a_r9_safe_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_o && en_i) |=> safe_o);

    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_ramp || in_closed) && !en_i) |=> ctrl_q.state == ST_IDLE);

endmodule

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;

    localparam int CLK_P = 10;
    localparam int DT = 3;
    localparam int ST = 4;
    localparam int DG = 10;
    localparam int TO = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic en = 1'b0, vin = 1'b0, vsec = 1'b0, vuv = 1'b0, auv = 1'b0, ovp = 1'b0;
    logic [2:0] duty;
    logic [4:0] refc;
    logic fbm, aux, pgn, safe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    softstart_seq #(
        .DUTY_TICKS(DT), .STEP_TICKS(ST), .DEGLITCH_TICKS(DG), .TIMEOUT_TICKS(TO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .vin_ok_i(vin),
        .vdd_sec_ok_i(vsec), .vdd_uv_ok_i(vuv), .aux_uv_ok_i(auv), .ovp_i(ovp),
        .duty_code_o(duty), .fb_mode_o(fbm), .ref_code_o(refc),
        .aux_reg_en_o(aux), .pg_n_o(pgn), .safe_o(safe)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic wait_ticks(input int n);
        int got = 0;
        while (got < n) begin
            @(posedge clk);
            if (tick) got++;
        end
        #(CLK_P/4);
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " duty"}, duty, 0);
        chk({tag, " ref"}, refc, 0);
        chk({tag, " fb_mode"}, fbm, 0);
        chk({tag, " aux_en"}, aux, 0);
        chk({tag, " pg_n"}, pgn, 1);
        chk({tag, " safe"}, safe, 0);
    endtask

    task automatic t_reset_idle();
        chk_idle("R1 reset");
        en = 1'b1; vin = 1'b0;
        repeat (5) edge1();
        chk_idle("R1 en without vin");
        en = 1'b0; vin = 1'b1;
        repeat (5) edge1();
        chk_idle("R1 vin without en");
    endtask

    task automatic t_full_start();
        vsec = 1'b0; vuv = 1'b0; auv = 1'b0; ovp = 1'b0;
        en = 1'b1; vin = 1'b1;
        edge1();
        chk("R2 duty first", duty, 1);
        wait_ticks(DT - 1);
        chk("R2 duty before step", duty, 1);
        wait_ticks(1);
        chk("R2 duty 2/8", duty, 2);
        wait_ticks(DT);
        chk("R2 duty 3/8", duty, 3);
        wait_ticks(DT);
        chk("R2 duty 4/8", duty, 4);
        wait_ticks(DT);
        chk("R2 duty saturate", duty, 4);
        vsec = 1'b1;
        edge1();
        chk("R3 fb_mode", fbm, 1);
        chk("R3 duty released", duty, 0);
        chk("R4 ref start", refc, 9);
        wait_ticks(ST - 1);
        chk("R4 ref hold first", refc, 9);
        wait_ticks(1);
        chk("R4 ref first step", refc, 13);
        for (int k = 1; k <= 6; k++) begin
            wait_ticks(ST);
            chk("R4 ref step", refc, 13 + 2 * k);
        end
        wait_ticks(ST);
        chk("R4 ref top hold", refc, 25);
        chk("R5 aux before uv ok", aux, 0);
        vuv = 1'b1;
        edge1();
        chk("R5 aux enable", aux, 1);
        chk("R6 pg not yet", pgn, 1);
        auv = 1'b1;
        wait_ticks(DG - 1);
        chk("R6 pg before window", pgn, 1);
        ovp = 1'b1;
        edge1();
        ovp = 1'b0;
        wait_ticks(DG - 1);
        chk("R6 pg after glitch restart", pgn, 1);
        wait_ticks(1);
        chk("R6 pg issued", pgn, 0);
        ovp = 1'b1;
        edge1();
        chk("R7 pg drops at once", pgn, 1);
        ovp = 1'b0;
        edge1();
        chk("R7 pg returns at once", pgn, 0);
        auv = 1'b0;
        edge1();
        chk("R7 aux uv drops pg", pgn, 1);
        chk("R5 aux stays", aux, 1);
        auv = 1'b1;
        en = 1'b0;
        edge1();
        chk_idle("R10 enable low");
    endtask

    task automatic t_timeout();
        vsec = 1'b0; vuv = 1'b0; auv = 1'b0;
        en = 1'b1; vin = 1'b1;
        edge1();
        chk("R8 ramp entered", duty, 1);
        wait_ticks(TO - 1);
        chk("R8 no safe yet", safe, 0);
        chk("R8 duty at limit", duty, 4);
        wait_ticks(1);
        chk("R8 safe", safe, 1);
        chk("R8 duty off", duty, 0);
        chk("R8 pg_n high", pgn, 1);
        vin = 1'b0;
        repeat (3) edge1();
        vin = 1'b1; vsec = 1'b1;
        repeat (3) edge1();
        chk("R9 safe latched", safe, 1);
        chk("R9 fb_mode off", fbm, 0);
        vsec = 1'b0;
        en = 1'b0;
        edge1();
        chk_idle("R9 cleared by enable");
        en = 1'b1;
        edge1();
        chk("R9 restart ramp", duty, 1);
        vin = 1'b0;
        edge1();
        chk_idle("R10 vin low in ramp");
        en = 1'b0;
    endtask

    task automatic t_reset_in_safe();
        vin = 1'b1; vsec = 1'b0; en = 1'b1;
        edge1();
        wait_ticks(TO);
        chk("R9 safe before reset", safe, 1);
        rst_n = 1'b0;
        #(CLK_P/4);
        chk("R9 reset clears safe", safe, 0);
        en = 1'b0;
        edge1();
        rst_n = 1'b1;
        edge1();
        chk_idle("R1 after reset");
    endtask

    initial begin
        repeat (3) edge1();
        rst_n = 1'b1;
        edge1();
        t_reset_idle();
        t_full_start();
        t_timeout();
        t_reset_in_safe();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule